// File: doc/BRIEF.md
# Streaming Histogram with Double-Buffered Bins

This block builds a histogram of a stream of converter samples, one measurement interval at a time. Each valid sample is mapped to a bin taken from the upper bits of its value. The count for that bin is read from an on-chip RAM, incremented and written back. The block accepts a new sample on every cycle, including runs of samples that land in the same bin, so no sample is ever dropped.

The bin counts live in two RAM pages. One page collects the interval in progress. The other page holds the finished histogram of the previous interval, and a host reads it through a simple index-in, count-out port with fixed latency. A sync pulse opens a new interval and swaps the roles of the two pages. The page that starts accumulating always begins at zero in every bin. This clearing costs no cycles: a per-word "written this interval" flag hides stale contents until a bin is first hit. Counters stop at all ones rather than wrapping.

Top module: `hist_top`

## Requirements
- R1: A sample's bin index is the top BIN_W bits of its DATA_W-bit value (bits DATA_W-1 down to DATA_W-BIN_W), giving 2^BIN_W bins. Values that differ only in the lower bits land in the same bin.
- R2: Each cycle with inValid high adds exactly one to the selected bin of the accumulating page. Cycles with inValid low change no count.
- R3: Samples on consecutive cycles that hit the same bin, or that alternate between bins, are all counted with no loss.
- R4: A cycle with inSync high starts a new interval and swaps the pages in that cycle. A valid sample on the sync cycle is counted in the new interval, not the one that is closing.
- R5: rdBin is sampled on a clock edge, and rdCount shows that bin's count from the completed page after the second edge. For reads issued at least one cycle after the sync, that count includes every sample before the sync, and it stays unchanged while the next interval accumulates.
- R6: Every bin of a page that becomes the accumulating page starts at zero, including bins that receive no sample in the interval. After reset, every bin reads zero.
- R7: A bin count that reaches 2^COUNT_W-1 stays there when further samples hit it. COUNT_W defaults to 32 and BIN_W to 4, and BIN_W up to 8 keeps both pages within 512 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | DATA_W | Sample value |
| inValid | input | 1 | Sample present this cycle |
| inSync | input | 1 | First cycle of a new interval |
| rdBin | input | BIN_W | Bin index to read from the completed page |
| rdCount | output | COUNT_W | Count of the requested bin, two edges after rdBin |

## Verification
A table of valid and invalid samples exercises several bin patterns. Values that differ only in their low bits separate bin decoding from full-value decoding. Three back-to-back hits on one bin expose a missing forwarding path. An A-B-A pattern catches forwarding applied to the wrong address. Later intervals send samples to a single bin on a page that still holds old counts, which shows whether untouched bins read as zero. They also place a sample on the sync cycle itself to show which interval it joins. A long run into one bin with a narrow counter separates saturation from wrapping.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic upd;      // count the current sample
    logic updPage;  // page receiving the update
    logic swap;     // interval boundary this cycle
    logic rdPage;   // completed page served to the host
  } hist_ctrl_t;

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSync,
  output hist_ctrl_t ctrl
);

  logic curPage;
  logic nextPage;

  // A sync cycle already targets the new page.
  assign nextPage = inSync ? ~curPage : curPage;

  always_ff @(posedge clk) begin
    if (!rstN) curPage <= 1'b0;
    else       curPage <= nextPage;
  end

  always_comb begin
    ctrl.upd     = inValid;
    ctrl.updPage = nextPage;
    ctrl.swap    = inSync;
    ctrl.rdPage  = ~nextPage;
  end

endmodule

// File: rtl/hist_datapath.sv
module hist_datapath
  import hist_pkg::*;
#(
  parameter int BIN_W   = 4,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  hist_ctrl_t         ctrl,
  input  logic [BIN_W-1:0]   inBin,
  input  logic [BIN_W-1:0]   rdBin,
  output logic [COUNT_W-1:0] rdCount
);

  localparam int ADDR_W = BIN_W + 1;
  localparam int NBINS  = 1 << BIN_W;
  localparam int WORDS  = 2 * NBINS;

  logic [COUNT_W-1:0] mem [WORDS];
  logic [WORDS-1:0]   touched;

  // Update pipeline: stage 1 holds the sample whose RAM word has returned.
  logic               s1Valid;
  logic [ADDR_W-1:0]  s1Addr;
  logic [COUNT_W-1:0] updQ;
  logic               lastValid;
  logic [ADDR_W-1:0]  lastAddr;
  logic [COUNT_W-1:0] lastData;
  logic [COUNT_W-1:0] oldCount;
  logic [COUNT_W-1:0] wrData;
  logic               fwdHit;

  // Host read pipeline.
  logic [COUNT_W-1:0] hostQ;
  logic               hostTouched;

  logic [ADDR_W-1:0] updAddr;
  logic [ADDR_W-1:0] hostAddr;
  assign updAddr  = {ctrl.updPage, inBin};
  assign hostAddr = {ctrl.rdPage, rdBin};

  // RAM read-before-write on the same edge, hence the forward register.
  always_ff @(posedge clk) begin
    if (s1Valid) mem[s1Addr] <= wrData;
    updQ  <= mem[updAddr];
    hostQ <= mem[hostAddr];
  end

  always_comb begin
    fwdHit = lastValid && (lastAddr == s1Addr);
    if (fwdHit)                oldCount = lastData;
    else if (touched[s1Addr])  oldCount = updQ;
    else                       oldCount = '0;
    wrData = (&oldCount) ? oldCount : oldCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid     <= 1'b0;
      s1Addr      <= '0;
      lastValid   <= 1'b0;
      lastAddr    <= '0;
      lastData    <= '0;
      touched     <= '0;
      hostTouched <= 1'b0;
      rdCount     <= '0;
    end else begin
      s1Valid     <= ctrl.upd;
      s1Addr      <= updAddr;
      lastValid   <= s1Valid;
      lastAddr    <= s1Addr;
      lastData    <= wrData;
      hostTouched <= touched[hostAddr];
      rdCount     <= hostTouched ? hostQ : '0;
      if (ctrl.swap) begin
        for (int b = 0; b < NBINS; b++)
          touched[{ctrl.updPage, BIN_W'(b)}] <= 1'b0;
      end
      if (s1Valid) touched[s1Addr] <= 1'b1;
    end
  end

endmodule

// File: rtl/hist_top.sv
module hist_top
  import hist_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BIN_W   = 4,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inValid,
  input  logic               inSync,
  input  logic [BIN_W-1:0]   rdBin,
  output logic [COUNT_W-1:0] rdCount
);

  hist_ctrl_t       ctrl;
  logic [BIN_W-1:0] inBin;

  assign inBin = inData[DATA_W-1 -: BIN_W];

  hist_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSync  (inSync),
    .ctrl    (ctrl)
  );

  hist_datapath #(
    .BIN_W   (BIN_W),
    .COUNT_W (COUNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inBin   (inBin),
    .rdBin   (rdBin),
    .rdCount (rdCount)
  );

endmodule

// File: rtl/hist_checker.sv
module hist_checker
  import hist_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input hist_ctrl_t         ctrl,
  input logic               s1Valid,
  input logic [ADDR_W-1:0]  s1Addr,
  input logic [COUNT_W-1:0] wrData
);

  p_upd_enters_pipe_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.upd |=> s1Valid);

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.upd |=> !s1Valid);

  p_b2b_increment_r3: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && $past(s1Valid) && s1Addr == $past(s1Addr) && !(&$past(wrData)))
      |-> wrData == COUNT_W'($past(wrData) + 1'b1));

  p_page_swap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.swap |-> ctrl.updPage != $past(ctrl.updPage));

  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.swap |-> ctrl.updPage == $past(ctrl.updPage));

  p_fresh_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.swap && ctrl.upd) |-> (s1Valid && wrData == COUNT_W'(1)));

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && $past(s1Valid) && s1Addr == $past(s1Addr) && (&$past(wrData)))
      |-> &wrData);

endmodule

bind hist_datapath hist_checker #(
  .ADDR_W  (ADDR_W),
  .COUNT_W (COUNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctrl    (ctrl),
  .s1Valid (s1Valid),
  .s1Addr  (s1Addr),
  .wrData  (wrData)
);

// File: tb/hist_top_tb.sv
module hist_top_tb;

  localparam int DATA_W  = 8;
  localparam int BIN_W   = 3;
  localparam int COUNT_W = 6;
  localparam int NBINS   = 1 << BIN_W;
  localparam int MAXC    = (1 << COUNT_W) - 1;

  logic               clk = 1'b0;
  logic               rstN;
  logic [DATA_W-1:0]  inData;
  logic               inValid;
  logic               inSync;
  logic [BIN_W-1:0]   rdBin;
  logic [COUNT_W-1:0] rdCount;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int model [NBINS];

  // {valid, data}; bin = data[7:5]
  localparam logic [8:0] VEC [16] = '{
    9'h100, 9'h11F, 9'h120, 9'h120, 9'h13F, 9'h0E0, 9'h140, 9'h1A0,
    9'h140, 9'h040, 9'h1FF, 9'h1E1, 9'h160, 9'h180, 9'h1C0, 9'h120
  };

  always #4ns clk = ~clk;

  hist_top #(.DATA_W(DATA_W), .BIN_W(BIN_W), .COUNT_W(COUNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inSync(inSync), .rdBin(rdBin), .rdCount(rdCount)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      finishRun();
    end
  end

  task automatic drive(input logic v, input logic [DATA_W-1:0] d, input logic s);
    @(negedge clk);
    inValid = v; inData = d; inSync = s;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b0;
  endtask

  task automatic checkBin(input int b, input int exp, input string req);
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b0; rdBin = BIN_W'(b);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (int'(rdCount) != exp) begin
      fails++;
      $display("FAIL %s bin %0d: actual %0d expected %0d", req, b, rdCount, exp);
    end
  endtask

  task automatic clearModel();
    for (int b = 0; b < NBINS; b++) model[b] = 0;
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inSync = 1'b0; inData = '0; rdBin = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // Reset: both pages empty (R6)
    for (int b = 0; b < NBINS; b++) checkBin(b, 0, "R6 reset");

    // Interval A from the table: R1 bin decode, R2 valid gating, R3 runs
    clearModel();
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][8], VEC[i][7:0], 1'b0);
      if (VEC[i][8]) model[VEC[i][7:5]]++;
    end
    drive(1'b0, '0, 1'b1);
    for (int b = 0; b < NBINS; b++) checkBin(b, model[b], "R1 R2 R3 table");

    // Interval B: only bin 2
    for (int i = 0; i < 4; i++) drive(1'b1, 8'h55, 1'b0);
    drive(1'b0, '0, 1'b1);
    checkBin(2, 4, "R2 single bin");
    checkBin(0, 0, "R6 untouched bin");

    // Interval C reuses A's page: only bin 5, then sync carrying a bin 7 sample
    for (int i = 0; i < 3; i++) drive(1'b1, 8'hB3, 1'b0);
    drive(1'b1, 8'hE0, 1'b1);
    for (int b = 0; b < NBINS; b++)
      checkBin(b, (b == 5) ? 3 : 0, "R6 R4 reused page");

    // Interval D: one more bin 7 sample; sync-cycle sample must join D
    drive(1'b1, 8'hF0, 1'b0);
    drive(1'b0, '0, 1'b1);
    checkBin(7, 2, "R4 sync sample in new interval");
    checkBin(5, 0, "R6 bin cleared");

    // Accumulate into the other page while reading the completed one (R5)
    for (int i = 0; i < 5; i++) drive(1'b1, 8'hE5, 1'b0);
    checkBin(7, 2, "R5 stable during accumulation");
    drive(1'b1, 8'hE5, 1'b0);
    checkBin(7, 2, "R5 stable during accumulation");
    drive(1'b0, '0, 1'b1);
    checkBin(7, 6, "R5 completed count");

    // Saturation: 70 back-to-back hits on bin 1 (R7)
    for (int i = 0; i < 70; i++) drive(1'b1, 8'h2A, 1'b0);
    drive(1'b0, '0, 1'b1);
    checkBin(1, MAXC, "R7 saturation");
    checkBin(0, 0, "R7 neighbour bin");

    idle();
    finishRun();
  end

endmodule